// File: doc/BRIEF.md
# Synchronous Exception Classifier and Vector Encoder

This block sits beside the execute stage of a simple in-order processor. For each instruction it samples what the decoder and the execute stage report: the opcode, whether it is supported or supervisor-only, the indexed addressing form, the control-transfer target, divide status, store status and the privilege level. From these it decides whether the instruction raises a synchronous exception. When several conditions apply to one instruction, it keeps only the highest-priority one.

The result is registered. One clock after an instruction is sampled, the block gives a one-cycle valid strobe together with the vector number, the byte offset of that vector in the vector table, and a cause code. Stacking, handler fetch and opcode decoding belong to neighbouring blocks. The line-A and line-F classes are derived here from the top nibble of the opcode.

Top module: `exc_classifier`

## Requirements
- R1: A control transfer (`xfer_i` high) whose target has bit 0 set raises an address error: vector 3, cause 1. An even target raises nothing, and an odd target with `xfer_i` low raises nothing.
- R2: When the indexed mode is in use (`idx_en_i` high), an address error (vector 3, cause 1) is raised by any of: a word-sized index register (`idx_word_i`), scale code 2'b11 (scale by 8), or the full-format form (`idx_full_i`). Scale codes 2'b00..2'b10 are legal. These fields are ignored when `idx_en_i` is low.
- R3: An unsupported opcode (`op_supported_i` low) with bits [15:12] equal to 4'hA gives vector 10, cause 3. One with 4'hF gives vector 11, cause 4. Supported opcodes in these classes raise nothing.
- R4: Any other unsupported opcode gives the illegal-instruction vector 4, cause 2.
- R5: A divide or remainder operation with a zero divisor gives vector 5 at offset 0x014, cause 6. A zero divisor flag without a divide operation is ignored.
- R6: Only a store to write-protected memory gives an access error: vector 2, cause 7. The write-protect flag alone raises nothing.
- R7: A supervisor-only instruction executed in user mode (`user_mode_i` high) gives vector 8, cause 5. In supervisor mode it raises nothing.
- R8: The offset output always equals the vector number multiplied by 4.
- R9: When conditions coincide, exactly one is reported, in this order: address error, then illegal / line-A / line-F, then privilege violation, then divide by zero, then access error.
- R10: The valid strobe rises on the clock edge after a sampled instruction (`inst_valid_i` high) with a condition. It lasts one cycle unless the next instruction also faults. Conditions present while `inst_valid_i` is low are ignored. While the strobe is low, the vector, offset and cause outputs are 0.
- R11: While `rst_ni` is low, all outputs are 0, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inst_valid_i | input | 1 | Instruction conditions are valid this cycle |
| opcode_i | input | 16 | First opcode word |
| op_supported_i | input | 1 | Decoder recognised the opcode |
| op_super_only_i | input | 1 | Opcode needs supervisor mode |
| user_mode_i | input | 1 | Processor is in user mode |
| xfer_i | input | 1 | Instruction transfers control |
| tgt_addr_i | input | 32 | Control-transfer target address |
| idx_en_i | input | 1 | Indexed effective address in use |
| idx_word_i | input | 1 | Index register is word-sized |
| idx_scale_i | input | 2 | Scale code: 0=x1, 1=x2, 2=x4, 3=x8 |
| idx_full_i | input | 1 | Full-format indexed form |
| div_op_i | input | 1 | Divide or remainder operation |
| div_zero_i | input | 1 | Divisor is zero |
| store_i | input | 1 | Instruction writes memory |
| wprot_i | input | 1 | Target memory is write-protected |
| exc_valid_o | output | 1 | Exception request strobe |
| exc_vector_o | output | 8 | Vector number |
| exc_offset_o | output | 10 | Vector-table byte offset |
| exc_cause_o | output | 3 | Cause code |

## Verification
The assertions check on every cycle that:
- the strobe only follows a sampled instruction;
- the outputs are zero while the strobe is low;
- the offset tracks the vector;
- an address error always wins;
- the access, divide and privilege causes appear only with their matching inputs.

Only the bench's scenarios can show three further points. The first is that each detection rule fires on exactly the right field values, such as scale code 3 against 2. The second is the full priority chain among coinciding conditions. The third is the exact one-cycle latency and the asynchronous clearing by reset.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W   = 8;
  localparam int CAUSE_W = 3;
  localparam int NREQ    = 7;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_ADDR    = 3'd1,
    CAUSE_ILLEGAL = 3'd2,
    CAUSE_LINE_A  = 3'd3,
    CAUSE_LINE_F  = 3'd4,
    CAUSE_PRIV    = 3'd5,
    CAUSE_DIVZ    = 3'd6,
    CAUSE_ACCESS  = 3'd7
  } cause_e;

  localparam logic [VEC_W-1:0] VEC_ACCESS  = 8'd2;
  localparam logic [VEC_W-1:0] VEC_ADDR    = 8'd3;
  localparam logic [VEC_W-1:0] VEC_ILLEGAL = 8'd4;
  localparam logic [VEC_W-1:0] VEC_DIVZ    = 8'd5;
  localparam logic [VEC_W-1:0] VEC_PRIV    = 8'd8;
  localparam logic [VEC_W-1:0] VEC_LINE_A  = 8'd10;
  localparam logic [VEC_W-1:0] VEC_LINE_F  = 8'd11;

  // request slot index -> cause, slot 0 has highest priority
  function automatic cause_e slot_cause(input int slot);
    case (slot)
      0:       return CAUSE_ADDR;
      1:       return CAUSE_LINE_A;
      2:       return CAUSE_LINE_F;
      3:       return CAUSE_ILLEGAL;
      4:       return CAUSE_PRIV;
      5:       return CAUSE_DIVZ;
      6:       return CAUSE_ACCESS;
      default: return CAUSE_NONE;
    endcase
  endfunction

  function automatic logic [VEC_W-1:0] cause_vec(input cause_e c);
    case (c)
      CAUSE_ADDR:    return VEC_ADDR;
      CAUSE_ILLEGAL: return VEC_ILLEGAL;
      CAUSE_LINE_A:  return VEC_LINE_A;
      CAUSE_LINE_F:  return VEC_LINE_F;
      CAUSE_PRIV:    return VEC_PRIV;
      CAUSE_DIVZ:    return VEC_DIVZ;
      CAUSE_ACCESS:  return VEC_ACCESS;
      default:       return '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_addr_chk.sv
module exc_addr_chk #(
  parameter int          AW        = 32,
  parameter int          ALIGN_LOG = 1,
  parameter int          SCALE_W   = 2,
  parameter logic [SCALE_W-1:0] BAD_SCALE = 2'b11
) (
  input  logic               xfer_i,
  input  logic [AW-1:0]      tgt_addr_i,
  input  logic               idx_en_i,
  input  logic               idx_word_i,
  input  logic [SCALE_W-1:0] idx_scale_i,
  input  logic               idx_full_i,
  output logic               odd_tgt_o,
  output logic               bad_idx_o,
  output logic               addr_err_o
);
  logic unused_tgt_hi;
  assign unused_tgt_hi = ^tgt_addr_i[AW-1:ALIGN_LOG];

  assign odd_tgt_o  = xfer_i && (|tgt_addr_i[ALIGN_LOG-1:0]);
  assign bad_idx_o  = idx_en_i && (idx_word_i || (idx_scale_i == BAD_SCALE) || idx_full_i);
  assign addr_err_o = odd_tgt_o || bad_idx_o;
endmodule

// File: rtl/exc_illegal_chk.sv
module exc_illegal_chk #(
  parameter int       OP_W  = 16,
  parameter logic [3:0] NIB_A = 4'hA,
  parameter logic [3:0] NIB_F = 4'hF
) (
  input  logic [OP_W-1:0] opcode_i,
  input  logic            supported_i,
  output logic            line_a_o,
  output logic            line_f_o,
  output logic            illegal_o
);
  localparam int NIB_LSB = OP_W - 4;

  logic [3:0] top_nib;
  logic       unused_low;
  assign top_nib    = opcode_i[OP_W-1:NIB_LSB];
  assign unused_low = ^opcode_i[NIB_LSB-1:0];

  assign line_a_o  = !supported_i && (top_nib == NIB_A);
  assign line_f_o  = !supported_i && (top_nib == NIB_F);
  assign illegal_o = !supported_i && (top_nib != NIB_A) && (top_nib != NIB_F);

  always_comb begin
    AST_ONE_ILLEGAL_CLASS: assert ($onehot0({line_a_o, line_f_o, illegal_o})); // R4
  end
endmodule

// File: rtl/exc_prio_enc.sv
module exc_prio_enc
  import exc_pkg::*;
#(
  parameter int N = NREQ
) (
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     grant_o,
  output cause_e           cause_o,
  output logic [VEC_W-1:0] vec_o
);
  // lowest index wins
  assign grant_o = req_i & (~req_i + N'(1));

  always_comb begin
    cause_o = CAUSE_NONE;
    for (int s = N - 1; s >= 0; s--) begin
      if (grant_o[s]) cause_o = slot_cause(s);
    end
  end

  assign vec_o = cause_vec(cause_o);

  always_comb begin
    AST_ONE_GRANT: assert ($onehot0(grant_o)); // R9
    AST_REQ_GRANTED: assert ((req_i == '0) || (cause_o != CAUSE_NONE)); // R9
  end
endmodule

// File: rtl/exc_classifier.sv
module exc_classifier
  import exc_pkg::*;
#(
  parameter int AW   = 32,
  parameter int OP_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   inst_valid_i,
  input  logic [OP_W-1:0]        opcode_i,
  input  logic                   op_supported_i,
  input  logic                   op_super_only_i,
  input  logic                   user_mode_i,
  input  logic                   xfer_i,
  input  logic [AW-1:0]          tgt_addr_i,
  input  logic                   idx_en_i,
  input  logic                   idx_word_i,
  input  logic [1:0]             idx_scale_i,
  input  logic                   idx_full_i,
  input  logic                   div_op_i,
  input  logic                   div_zero_i,
  input  logic                   store_i,
  input  logic                   wprot_i,
  output logic                   exc_valid_o,
  output logic [VEC_W-1:0]       exc_vector_o,
  output logic [VEC_W+1:0]       exc_offset_o,
  output logic [CAUSE_W-1:0]     exc_cause_o
);
  localparam int OFF_W = VEC_W + 2;

  logic odd_tgt, bad_idx, addr_err;
  logic line_a, line_f, illegal;
  logic priv_err, divz_err, acc_err;
  logic [NREQ-1:0] req, grant;
  cause_e          cause_d;
  logic [VEC_W-1:0] vec_d;

  exc_addr_chk #(.AW(AW)) u_addr (
    .xfer_i      (xfer_i),
    .tgt_addr_i  (tgt_addr_i),
    .idx_en_i    (idx_en_i),
    .idx_word_i  (idx_word_i),
    .idx_scale_i (idx_scale_i),
    .idx_full_i  (idx_full_i),
    .odd_tgt_o   (odd_tgt),
    .bad_idx_o   (bad_idx),
    .addr_err_o  (addr_err)
  );

  exc_illegal_chk #(.OP_W(OP_W)) u_ill (
    .opcode_i    (opcode_i),
    .supported_i (op_supported_i),
    .line_a_o    (line_a),
    .line_f_o    (line_f),
    .illegal_o   (illegal)
  );

  assign priv_err = op_super_only_i && user_mode_i;
  assign divz_err = div_op_i && div_zero_i;
  assign acc_err  = store_i && wprot_i;

  // slot order is the priority order
  assign req = {acc_err, divz_err, priv_err, illegal, line_f, line_a, addr_err}
               & {NREQ{inst_valid_i}};

  exc_prio_enc #(.N(NREQ)) u_prio (
    .req_i   (req),
    .grant_o (grant),
    .cause_o (cause_d),
    .vec_o   (vec_d)
  );

  logic unused_flags;
  assign unused_flags = odd_tgt ^ bad_idx ^ (^grant);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_valid_o  <= 1'b0;
      exc_vector_o <= '0;
      exc_offset_o <= '0;
      exc_cause_o  <= '0;
    end else begin
      exc_valid_o  <= (cause_d != CAUSE_NONE);
      exc_vector_o <= vec_d;
      exc_offset_o <= {vec_d, 2'b00};
      exc_cause_o  <= cause_d;
    end
  end

  AST_STROBE_AFTER_INST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_o |-> $past(inst_valid_i)); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_valid_o |-> (exc_vector_o == '0 && exc_offset_o == '0 && exc_cause_o == '0)); // R10
  AST_OFFSET_X4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_offset_o == OFF_W'({exc_vector_o, 2'b00})); // R8
  AST_ADDR_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inst_valid_i && addr_err) |-> exc_cause_o == CAUSE_ADDR); // R9
  AST_ACCESS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_cause_o == CAUSE_ACCESS) |-> $past(store_i && wprot_i)); // R6
  AST_DIVZ_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_cause_o == CAUSE_DIVZ) |-> (exc_vector_o == 8'd5 && exc_offset_o == 10'h014)); // R5
  AST_PRIV_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_cause_o == CAUSE_PRIV) |-> $past(user_mode_i && op_super_only_i)); // R7
endmodule

// File: tb/exc_classifier_test.sv
module exc_classifier_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 24;
  localparam int WD_LIMIT = 5000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inst_valid_i = 1'b0;
  logic [15:0] opcode_i = '0;
  logic        op_supported_i = 1'b1;
  logic        op_super_only_i = 1'b0;
  logic        user_mode_i = 1'b0;
  logic        xfer_i = 1'b0;
  logic [31:0] tgt_addr_i = '0;
  logic        idx_en_i = 1'b0;
  logic        idx_word_i = 1'b0;
  logic [1:0]  idx_scale_i = '0;
  logic        idx_full_i = 1'b0;
  logic        div_op_i = 1'b0;
  logic        div_zero_i = 1'b0;
  logic        store_i = 1'b0;
  logic        wprot_i = 1'b0;
  logic        exc_valid_o;
  logic [7:0]  exc_vector_o;
  logic [9:0]  exc_offset_o;
  logic [2:0]  exc_cause_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  exc_classifier uut (
    .clk_i, .rst_ni, .inst_valid_i, .opcode_i, .op_supported_i, .op_super_only_i,
    .user_mode_i, .xfer_i, .tgt_addr_i, .idx_en_i, .idx_word_i, .idx_scale_i,
    .idx_full_i, .div_op_i, .div_zero_i, .store_i, .wprot_i,
    .exc_valid_o, .exc_vector_o, .exc_offset_o, .exc_cause_o
  );

  // {xfer,odd} {en,word,scale2,full} {sup,nib4} {so,user} {div,zero} {store,wprot} vec cause
  localparam logic [28:0] TBL [NV] = '{
    {2'b11, 5'b00000, 5'h11, 2'b00, 2'b00, 2'b00, 8'd3,  3'd1}, // R1 odd target
    {2'b10, 5'b00000, 5'h11, 2'b00, 2'b00, 2'b00, 8'd0,  3'd0}, // R1 even target
    {2'b01, 5'b00000, 5'h11, 2'b00, 2'b00, 2'b00, 8'd0,  3'd0}, // R1 odd, no transfer
    {2'b00, 5'b11000, 5'h11, 2'b00, 2'b00, 2'b00, 8'd3,  3'd1}, // R2 word index
    {2'b00, 5'b10110, 5'h11, 2'b00, 2'b00, 2'b00, 8'd3,  3'd1}, // R2 scale 8
    {2'b00, 5'b10100, 5'h11, 2'b00, 2'b00, 2'b00, 8'd0,  3'd0}, // R2 scale 4 legal
    {2'b00, 5'b10001, 5'h11, 2'b00, 2'b00, 2'b00, 8'd3,  3'd1}, // R2 full format
    {2'b00, 5'b01111, 5'h11, 2'b00, 2'b00, 2'b00, 8'd0,  3'd0}, // R2 fields ignored
    {2'b00, 5'b00000, 5'h0A, 2'b00, 2'b00, 2'b00, 8'd10, 3'd3}, // R3 line A
    {2'b00, 5'b00000, 5'h0F, 2'b00, 2'b00, 2'b00, 8'd11, 3'd4}, // R3 line F
    {2'b00, 5'b00000, 5'h04, 2'b00, 2'b00, 2'b00, 8'd4,  3'd2}, // R4 generic illegal
    {2'b00, 5'b00000, 5'h1A, 2'b00, 2'b00, 2'b00, 8'd0,  3'd0}, // R3 supported line A
    {2'b00, 5'b00000, 5'h11, 2'b11, 2'b00, 2'b00, 8'd8,  3'd5}, // R7 user mode
    {2'b00, 5'b00000, 5'h11, 2'b10, 2'b00, 2'b00, 8'd0,  3'd0}, // R7 supervisor mode
    {2'b00, 5'b00000, 5'h11, 2'b00, 2'b11, 2'b00, 8'd5,  3'd6}, // R5 div zero
    {2'b00, 5'b00000, 5'h11, 2'b00, 2'b01, 2'b00, 8'd0,  3'd0}, // R5 zero, no divide
    {2'b00, 5'b00000, 5'h11, 2'b00, 2'b00, 2'b11, 8'd2,  3'd7}, // R6 protected store
    {2'b00, 5'b00000, 5'h11, 2'b00, 2'b00, 2'b01, 8'd0,  3'd0}, // R6 protect, no store
    {2'b00, 5'b00000, 5'h11, 2'b00, 2'b00, 2'b10, 8'd0,  3'd0}, // R6 open store
    {2'b11, 5'b10110, 5'h0F, 2'b11, 2'b11, 2'b11, 8'd3,  3'd1}, // R9 all conditions
    {2'b00, 5'b00000, 5'h0F, 2'b11, 2'b11, 2'b11, 8'd11, 3'd4}, // R9 line F first
    {2'b00, 5'b00000, 5'h11, 2'b11, 2'b11, 2'b11, 8'd8,  3'd5}, // R9 privilege first
    {2'b00, 5'b00000, 5'h11, 2'b00, 2'b11, 2'b11, 8'd5,  3'd6}, // R9 divide first
    {2'b00, 5'b00000, 5'h04, 2'b11, 2'b00, 2'b00, 8'd4,  3'd2}  // R9 illegal over priv
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [28:0] e);
    xfer_i          = e[28];
    tgt_addr_i      = 32'h0000_1000 | {31'd0, e[27]};
    idx_en_i        = e[26];
    idx_word_i      = e[25];
    idx_scale_i     = e[24:23];
    idx_full_i      = e[22];
    op_supported_i  = e[21];
    opcode_i        = {e[20:17], 12'h3C5};
    op_super_only_i = e[16];
    user_mode_i     = e[15];
    div_op_i        = e[14];
    div_zero_i      = e[13];
    store_i         = e[12];
    wprot_i         = e[11];
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < WD_LIMIT; c++) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", WD_LIMIT, 0);
    finish_run();
  end

  initial begin
    // R11 reset state
    repeat (2) @(negedge clk_i);
    chk(exc_valid_o == 1'b0 && exc_vector_o == 0 && exc_cause_o == 0 && exc_offset_o == 0,
        "R11 reset", exc_vector_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i]);
      inst_valid_i = 1'b1;
      @(negedge clk_i);
      chk(exc_valid_o == (TBL[i][10:3] != 0), $sformatf("R10 valid entry %0d", i),
          exc_valid_o, int'(TBL[i][10:3] != 0));
      chk(exc_vector_o == TBL[i][10:3], $sformatf("R1-7 vector entry %0d", i),
          exc_vector_o, TBL[i][10:3]);
      chk(exc_cause_o == TBL[i][2:0], $sformatf("R9 cause entry %0d", i),
          exc_cause_o, TBL[i][2:0]);
      chk(exc_offset_o == {TBL[i][10:3], 2'b00}, $sformatf("R8 offset entry %0d", i),
          exc_offset_o, {TBL[i][10:3], 2'b00});
    end

    // R5 exact offset
    apply({2'b00, 5'b0, 5'h11, 2'b00, 2'b11, 2'b00, 8'd0, 3'd0});
    @(negedge clk_i);
    chk(exc_offset_o == 10'h014, "R5 offset 0x014", exc_offset_o, 20);

    // R10 conditions ignored while inst_valid_i low
    apply({2'b11, 5'b11111, 5'h0F, 2'b11, 2'b11, 2'b11, 8'd0, 3'd0});
    inst_valid_i = 1'b0;
    @(negedge clk_i);
    chk(exc_valid_o == 1'b0 && exc_vector_o == 0 && exc_cause_o == 0, "R10 ignored",
        exc_vector_o, 0);

    // R10 single-cycle pulse with one-edge latency
    apply({2'b00, 5'b0, 5'h04, 2'b00, 2'b00, 2'b00, 8'd0, 3'd0});
    inst_valid_i = 1'b1;
    @(posedge clk_i);
    #1;
    chk(exc_valid_o == 1'b1, "R10 rise at first edge", exc_valid_o, 1);
    @(negedge clk_i);
    inst_valid_i = 1'b0;
    apply({2'b00, 5'b0, 5'h11, 2'b00, 2'b00, 2'b00, 8'd0, 3'd0});
    @(negedge clk_i);
    chk(exc_valid_o == 1'b0 && exc_vector_o == 0, "R10 pulse ends", exc_valid_o, 0);

    // R11 asynchronous reset clears a pending strobe
    apply({2'b00, 5'b0, 5'h11, 2'b00, 2'b00, 2'b11, 8'd0, 3'd0});
    inst_valid_i = 1'b1;
    @(negedge clk_i);
    chk(exc_cause_o == 3'd7, "R6 before reset", exc_cause_o, 7);
    #2;
    rst_ni = 1'b0;
    #1;
    chk(exc_valid_o == 1'b0 && exc_cause_o == 0 && exc_offset_o == 0, "R11 async clear",
        exc_cause_o, 0);
    inst_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(exc_valid_o == 1'b0, "R11 quiet after reset", exc_valid_o, 0);

    finish_run();
  end
endmodule